// File: doc/BRIEF.md
# Headphone Output Pop-Free Enable Sequencer

This block brings a stereo headphone driver up and down in a fixed order so that no audible click reaches the listener. On an enable request it turns on the bias of both channels. After a minimum settling gap it turns on the intermediate stage, but only once the output path is reported as configured. It then asks an external offset-cancellation engine to run and waits for both channels to report completion. Only after that does it turn on the output stage and finally lift the output short.

When the request is withdrawn, the same steps are undone in reverse, one per clock. If cancellation does not finish within a programmable number of cycles, the sequencer raises a sticky error and backs out. When cancellation completes, the signed per-channel correction words reported by the engine are captured and held for readback.

Top module: `hp_pop_seq`

## Requirements
- R1: After reset every enable vector, `cal_req`, `done`, `cal_err` and `cal_flags` read 0, and both readback words read 0.
- R2: With `en_req` high in idle and no pending error, `bias_en` becomes 2'b11 one clock later.
- R3: `mid_en` rises no sooner than GAP_CYC+1 clocks after `bias_en`, and only in the clock after `path_ready` was high. Precisely, it rises max(GAP_CYC+1, p+1) clocks after bias, where p is the clock at which `path_ready` goes high. `cal_req` rises together with `mid_en`.
- R4: The completion input `cal_ok` has bit 1 for the right channel and bit 0 for the left channel. A single channel completing is accumulated in `cal_flags` (same bit order) while `drv_en` stays 0. `drv_en` becomes 2'b11, and `cal_req` drops, one clock after `cal_ok` is 2'b11.
- R5: `unshort` becomes 2'b11 and `done` becomes 1 one clock after `drv_en` rises.
- R6: `trim_rd_l` and `trim_rd_r` are 8-bit two's complement words (0.25 mV per LSB). They load `trim_in_l` and `trim_in_r` in the clock where both channels complete, and otherwise hold their value.
- R7: When `en_req` falls while `done` is high, the following happen on four successive clocks: `unshort` and `done` clear, then `drv_en` clears, then `mid_en` clears, then `bias_en` clears.
- R8: If cancellation is still incomplete CAL_LIMIT+1 clocks after `cal_req` rises, then on that clock `cal_err` sets, `cal_req` and `mid_en` clear, and `bias_en` is still set; `bias_en` clears one clock later. While `cal_err` is set, a held `en_req` does not restart the sequence. `cal_err` clears one clock after `en_req` is low in idle.
- R9: If `en_req` falls during the settling gap, `bias_en` clears the next clock. If it falls during cancellation, `mid_en` and `cal_req` clear the next clock and `bias_en` clears the clock after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Level request: high to bring up, low to shut down |
| path_ready | input | 1 | Output signal path is configured |
| cal_ok | input | 2 | Offset cancellation complete, bit 1 right, bit 0 left |
| trim_in_l | input | TRIM_W | Correction word from the cancellation engine, left |
| trim_in_r | input | TRIM_W | Correction word from the cancellation engine, right |
| bias_en | output | 2 | Channel bias enable {right,left} |
| mid_en | output | 2 | Intermediate stage enable {right,left} |
| drv_en | output | 2 | Output stage enable {right,left} |
| unshort | output | 2 | Output short removed {right,left} |
| cal_req | output | 1 | Request to run offset cancellation |
| done | output | 1 | Both channels fully enabled |
| cal_err | output | 1 | Cancellation timed out (sticky) |
| cal_flags | output | 2 | Accumulated per-channel completion, {right,left} |
| trim_rd_l | output | TRIM_W | Captured correction word, left |
| trim_rd_r | output | TRIM_W | Captured correction word, right |

## Verification
The bench sweeps the arrival time of `path_ready` relative to the settling gap and measures the exact bias-to-intermediate delay. A design that counts the gap from the wrong edge, or ignores the path flag, shows up as an early or late rise. It completes the two channels in every order, with changing correction words, to catch a sequencer that advances on one channel alone, swaps the flag bits, or keeps tracking the correction inputs after capture. It also holds cancellation off until the limit, and aborts during the gap and during cancellation. These cases expose an off-by-one timeout, a shutdown that skips or reorders a step, and an error that lets a held request restart the sequence.

// File: rtl/hp_seq_pkg.sv
package hp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_CAL,
        ST_DRV,
        ST_ON,
        ST_OFF_DRV,
        ST_OFF_MID,
        ST_OFF_BIAS
    } hp_state_e;

    typedef struct packed {
        hp_state_e  st;
        logic [1:0] bias;
        logic [1:0] mid;
        logic [1:0] drv;
        logic [1:0] unshort;
        logic       cal_req;
        logic       done;
        logic       err;
        logic [1:0] flags;
    } hp_seq_regs_t;

endpackage

// File: rtl/hp_down_ctr.sv
module hp_down_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/hp_trim_hold.sv
module hp_trim_hold #(
    parameter int unsigned TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [TRIM_W-1:0] in_l,
    input  logic [TRIM_W-1:0] in_r,
    output logic [TRIM_W-1:0] out_l,
    output logic [TRIM_W-1:0] out_r
);
    logic [2*TRIM_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (capture) hold_d = {in_r, in_l};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign out_l = hold_q[TRIM_W-1:0];
    assign out_r = hold_q[2*TRIM_W-1:TRIM_W];
endmodule

// File: rtl/hp_pop_seq.sv
module hp_pop_seq
    import hp_seq_pkg::*;
#(
    parameter int unsigned GAP_CYC   = 2000,
    parameter int unsigned CAL_LIMIT = 100000,
    parameter int unsigned TRIM_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              path_ready,
    input  logic [1:0]        cal_ok,
    input  logic [TRIM_W-1:0] trim_in_l,
    input  logic [TRIM_W-1:0] trim_in_r,
    output logic [1:0]        bias_en,
    output logic [1:0]        mid_en,
    output logic [1:0]        drv_en,
    output logic [1:0]        unshort,
    output logic              cal_req,
    output logic              done,
    output logic              cal_err,
    output logic [1:0]        cal_flags,
    output logic [TRIM_W-1:0] trim_rd_l,
    output logic [TRIM_W-1:0] trim_rd_r
);
    localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);
    localparam int unsigned TMO_W = $clog2(CAL_LIMIT + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYC);
    localparam logic [TMO_W-1:0] TMO_LOAD = TMO_W'(CAL_LIMIT);

    hp_seq_regs_t r_d, r_q;
    logic gap_load, gap_zero;
    logic tmo_load, tmo_zero;
    logic trim_cap;

    // Settling gap between bias and intermediate stage
    hp_down_ctr #(.W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (GAP_LOAD),
        .zero     (gap_zero)
    );

    // Cancellation watchdog
    hp_down_ctr #(.W(TMO_W)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmo_load),
        .load_val (TMO_LOAD),
        .zero     (tmo_zero)
    );

    hp_trim_hold #(.TRIM_W(TRIM_W)) u_trim (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (trim_cap),
        .in_l    (trim_in_l),
        .in_r    (trim_in_r),
        .out_l   (trim_rd_l),
        .out_r   (trim_rd_r)
    );

    always_comb begin
        r_d      = r_q;
        gap_load = 1'b0;
        tmo_load = 1'b0;
        trim_cap = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!en_req) begin
                    r_d.err = 1'b0;
                end else if (!r_q.err) begin
                    r_d.st    = ST_GAP;
                    r_d.bias  = 2'b11;
                    r_d.flags = 2'b00;
                    gap_load  = 1'b1;
                end
            end
            ST_GAP: begin
                if (!en_req) begin
                    r_d.st   = ST_IDLE;
                    r_d.bias = 2'b00;
                end else if (gap_zero && path_ready) begin
                    r_d.st      = ST_CAL;
                    r_d.mid     = 2'b11;
                    r_d.cal_req = 1'b1;
                    tmo_load    = 1'b1;
                end
            end
            ST_CAL: begin
                r_d.flags = r_q.flags | cal_ok;
                if (!en_req) begin
                    r_d.st      = ST_OFF_BIAS;
                    r_d.mid     = 2'b00;
                    r_d.cal_req = 1'b0;
                end else if (cal_ok == 2'b11) begin
                    r_d.st      = ST_DRV;
                    r_d.drv     = 2'b11;
                    r_d.cal_req = 1'b0;
                    trim_cap    = 1'b1;
                end else if (tmo_zero) begin
                    r_d.st      = ST_OFF_BIAS;
                    r_d.mid     = 2'b00;
                    r_d.cal_req = 1'b0;
                    r_d.err     = 1'b1;
                end
            end
            ST_DRV: begin
                r_d.st      = ST_ON;
                r_d.unshort = 2'b11;
                r_d.done    = 1'b1;
            end
            ST_ON: begin
                if (!en_req) begin
                    r_d.st      = ST_OFF_DRV;
                    r_d.unshort = 2'b00;
                    r_d.done    = 1'b0;
                end
            end
            ST_OFF_DRV: begin
                r_d.st  = ST_OFF_MID;
                r_d.drv = 2'b00;
            end
            ST_OFF_MID: begin
                r_d.st  = ST_OFF_BIAS;
                r_d.mid = 2'b00;
            end
            ST_OFF_BIAS: begin
                r_d.st   = ST_IDLE;
                r_d.bias = 2'b00;
            end
            default: begin
                r_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bias_en   = r_q.bias;
    assign mid_en    = r_q.mid;
    assign drv_en    = r_q.drv;
    assign unshort   = r_q.unshort;
    assign cal_req   = r_q.cal_req;
    assign done      = r_q.done;
    assign cal_err   = r_q.err;
    assign cal_flags = r_q.flags;
endmodule

// File: rtl/hp_pop_seq_chk.sv
module hp_pop_seq_chk #(
    parameter int unsigned TRIM_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              path_ready,
    input logic [1:0]        cal_ok,
    input logic [1:0]        bias_en,
    input logic [1:0]        mid_en,
    input logic [1:0]        drv_en,
    input logic [1:0]        unshort,
    input logic              cal_req,
    input logic              done,
    input logic              cal_err,
    input logic [TRIM_W-1:0] trim_rd_l,
    input logic [TRIM_W-1:0] trim_rd_r
);
    assert_mid_needs_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mid_en[0]) |-> ($past(path_ready) && bias_en == 2'b11 && cal_req));

    assert_drv_after_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en[0]) |-> ($past(cal_ok) == 2'b11 && !cal_req));

    assert_done_full_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (unshort == 2'b11 && drv_en == 2'b11 && mid_en == 2'b11));

    assert_trim_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cal_req) |-> ($stable(trim_rd_l) && $stable(trim_rd_r)));

    assert_drv_off_after_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en[0]) |-> (unshort == 2'b00 && mid_en == 2'b11));

    assert_bias_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bias_en[0]) |-> (mid_en == 2'b00 && drv_en == 2'b00));

    assert_timeout_backout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_err) |-> (!cal_req && mid_en == 2'b00 && bias_en == 2'b11));
endmodule

bind hp_pop_seq hp_pop_seq_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .path_ready (path_ready),
    .cal_ok     (cal_ok),
    .bias_en    (bias_en),
    .mid_en     (mid_en),
    .drv_en     (drv_en),
    .unshort    (unshort),
    .cal_req    (cal_req),
    .done       (done),
    .cal_err    (cal_err),
    .trim_rd_l  (trim_rd_l),
    .trim_rd_r  (trim_rd_r)
);

// File: tb/hp_pop_seq_tb.sv
`timescale 1ns/1ps
module hp_pop_seq_tb;
    localparam int GAP = 5;
    localparam int LIM = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_req = 1'b0;
    logic       path_ready = 1'b0;
    logic [1:0] cal_ok = 2'b00;
    logic [7:0] trim_in_l = 8'h00;
    logic [7:0] trim_in_r = 8'h00;
    logic [1:0] bias_en, mid_en, drv_en, unshort, cal_flags;
    logic       cal_req, done, cal_err;
    logic [7:0] trim_rd_l, trim_rd_r;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hp_pop_seq #(.GAP_CYC(GAP), .CAL_LIMIT(LIM), .TRIM_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .path_ready(path_ready),
        .cal_ok(cal_ok), .trim_in_l(trim_in_l), .trim_in_r(trim_in_r),
        .bias_en(bias_en), .mid_en(mid_en), .drv_en(drv_en), .unshort(unshort),
        .cal_req(cal_req), .done(done), .cal_err(cal_err), .cal_flags(cal_flags),
        .trim_rd_l(trim_rd_l), .trim_rd_r(trim_rd_r)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Bring-up with path_ready raised p clocks after bias is seen
    task automatic bring_up(input int p, input int order, input logic [7:0] tl, input logic [7:0] tr);
        int m;
        int exp_m;
        en_req = 1'b1;
        path_ready = 1'b0;
        step();
        chk(bias_en, 3, "R2 bias on");
        chk(mid_en, 0, "R3 mid off early");
        m = 0;
        if (p == 0) path_ready = 1'b1;
        while (mid_en != 2'b11 && m < 40) begin
            step();
            m++;
            if (m == p) path_ready = 1'b1;
        end
        exp_m = (GAP + 1 > p + 1) ? GAP + 1 : p + 1;
        chk(m, exp_m, "R3 bias-to-mid clocks");
        chk(cal_req, 1, "R3 cal_req with mid");
        chk(drv_en, 0, "R4 drv off before completion");
        trim_in_l = tl;
        trim_in_r = tr;
        if (order != 0) begin
            cal_ok = (order == 1) ? 2'b01 : 2'b10;
            step();
            cal_ok = 2'b00;
            chk(cal_flags, (order == 1) ? 1 : 2, "R4 single flag");
            chk(drv_en, 0, "R4 wait for both");
            step();
            cal_ok = (order == 1) ? 2'b10 : 2'b01;
            step();
            chk(cal_flags, 3, "R4 flags after second");
            chk(drv_en, 0, "R4 one channel per clock");
            cal_ok = 2'b11;
        end else begin
            cal_ok = 2'b11;
        end
        step();
        cal_ok = 2'b00;
        chk(drv_en, 3, "R4 drv on");
        chk(cal_req, 0, "R4 cal_req drop");
        chk(unshort, 0, "R5 short held");
        chk(trim_rd_l, tl, "R6 trim left");
        chk(trim_rd_r, tr, "R6 trim right");
        trim_in_l = ~tl;
        trim_in_r = tr + 8'd17;
        step();
        chk(unshort, 3, "R5 unshort");
        chk(done, 1, "R5 done");
        step(); step();
        chk(trim_rd_l, tl, "R6 hold left");
        chk(trim_rd_r, tr, "R6 hold right");
    endtask

    task automatic shut_down();
        en_req = 1'b0;
        path_ready = 1'b0;
        step();
        chk({unshort, drv_en}, 4'b0011, "R7 step1 short");
        chk(done, 0, "R7 done clear");
        step();
        chk({drv_en, mid_en}, 4'b0011, "R7 step2 drv");
        step();
        chk({mid_en, bias_en}, 4'b0011, "R7 step3 mid");
        step();
        chk(bias_en, 0, "R7 step4 bias");
    endtask

    initial begin
        int n;
        repeat (3) step();
        chk({bias_en, mid_en, drv_en, unshort}, 0, "R1 enables reset");
        chk({cal_req, done, cal_err, cal_flags}, 0, "R1 flags reset");
        chk({trim_rd_l, trim_rd_r}, 0, "R1 trims reset");
        rst_n = 1'b1;
        step();
        chk(bias_en, 0, "R1 idle after reset");

        for (int pi = 0; pi < 3; pi++) begin
            for (int o = 0; o < 3; o++) begin
                int p;
                logic [7:0] tl, tr;
                p  = (pi == 0) ? 0 : (pi == 1) ? 3 : GAP + 3;
                tl = 8'(pi * 77 - o * 45 - 128);
                tr = 8'(o * 53 + pi * 31 + 100);
                bring_up(p, o, tl, tr);
                shut_down();
                step();
            end
        end

        // Timeout
        en_req = 1'b1;
        path_ready = 1'b1;
        step();
        while (mid_en != 2'b11) step();
        n = 0;
        while (!cal_err && n < 40) begin step(); n++; end
        chk(n, LIM + 1, "R8 timeout clocks");
        chk({cal_req, mid_en, bias_en}, 5'b0_00_11, "R8 backout");
        step();
        chk(bias_en, 0, "R8 bias off");
        repeat (5) step();
        chk(bias_en, 0, "R8 no restart while error");
        chk(cal_err, 1, "R8 error sticky");
        en_req = 1'b0;
        step();
        chk(cal_err, 0, "R8 error clears");

        // Abort during gap
        en_req = 1'b1;
        path_ready = 1'b0;
        step(); step();
        en_req = 1'b0;
        step();
        chk(bias_en, 0, "R9 gap abort");
        step();

        // Abort during cancellation
        en_req = 1'b1;
        path_ready = 1'b1;
        step();
        while (mid_en != 2'b11) step();
        en_req = 1'b0;
        step();
        chk({cal_req, mid_en, bias_en}, 5'b0_00_11, "R9 cal abort step1");
        step();
        chk(bias_en, 0, "R9 cal abort step2");

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule